// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block gathers eight interrupt inputs, ranks them by a rotating priority and raises a single interrupt line to the host. Software configures it through a byte-wide register port with two addresses. An initialization sequence starts with a write to address 0 that has bit 4 set. Later writes carry operational commands: the input mask, a choice of the lowest-priority level, specific and non-specific end-of-interrupt, and a choice of which register address 0 reads back.

The host services the block by polling. A poll command arms the next read of address 0. That read returns an active flag and the winning level, and it also acknowledges that level: its in-service bit is set and its latched request is cleared. A level already in service blocks its own level and every level below it until an end-of-interrupt clears it. Each input is edge- or level-sensitive, chosen by a per-input configuration pin. One configuration byte marks which inputs carry cascaded slave requests. The block reports it and flags when a cascade input is the winner, but it models no slave bus.

The register port accepts one access per cycle, either a read or a write. It never stalls, so it has no back-pressure. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, in-service and request registers are zero, level 0 has the highest priority (order 0..7), address 0 reads return the request register, `int_out` is low and `casc_sel` is 0x00.
- R2: A write to address 0 with bit 4 set starts initialization. It clears the mask and the in-service register, restores level 0 as highest, selects request-register readback and cancels a pending poll. The next address-1 writes are taken as the vector word (discarded), then the cascade byte, then a fourth word only when bit 0 of the starting write was 1. The address-1 write after that loads the mask.
- R3: Outside initialization, an address-1 write loads the mask and an address-1 read returns it. Mask bit n keeps input n out of `int_out` and out of poll results, but the request is still latched and visible in the request register.
- R4: An address-0 write of 0xC0|L (bits 4 and 3 clear) makes level L the lowest priority. Service order then runs L+1, L+2, ... modulo 8.
- R5: An address-0 write of 0x60|L clears only in-service bit L. A write of 0x20 clears the in-service bit of the highest-priority level in service.
- R6: `int_out` is high exactly when the highest-priority unmasked request outranks every in-service level, or when nothing is in service.
- R7: An address-0 write with bit 4 clear and bits 3 and 2 set arms a poll. The next address-0 read returns bit 7 = 1, bits 6..3 = 0 and bits 2..0 = the winning level when `int_out` would be high; otherwise it returns 0x00. An active poll sets that level's in-service bit and clears its edge-latched request.
- R8: An address-0 write of 0x0A selects request-register readback and 0x0B selects in-service readback for later non-poll reads of address 0.
- R9: With `irq_level[n]` = 1, request bit n follows the line one cycle late and an acknowledge does not clear it. With `irq_level[n]` = 0, a rising edge latches request bit n, which stays set until it is acknowledged; a line held high does not request again.
- R10: `casc_sel` presents the cascade byte. `casc_req` is high when `int_out` is high and the winning level has its bit set in that byte.
- R11: `bus_rdata` updates on the clock edge that samples `bus_rd` and then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 8 | Interrupt request inputs, synchronous to clk |
| irq_level | input | 8 | Per-input sensitivity: 1 = level, 0 = rising edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| int_out | output | 1 | Interrupt request to host |
| casc_sel | output | 8 | Programmed cascade-input byte |
| casc_req | output | 1 | Winning request sits on a cascade input |

## Verification
A corrupt priority pointer shows at the next poll read, which returns the wrong winner as soon as two unmasked requests compete. A stuck in-service bit shows at `int_out` on the cycle after the next request: the line stays low when it should rise, or rises early if the bit clears too soon. A request register that latches wrongly shows one cycle after the input changes, in request readback and in `int_out`. A slip in the initialization counter shows at the next address-1 read, because the mask holds a value meant for another word.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_VEC,
    SEQ_CASC,
    SEQ_MODE
  } seq_t;

  typedef enum logic {
    SEL_REQ,
    SEL_SVC
  } rdsel_t;

  localparam logic [2:0] OP_NS_EOI  = 3'b001;
  localparam logic [2:0] OP_SP_EOI  = 3'b011;
  localparam logic [2:0] OP_SET_LOW = 3'b110;
endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
  import pic_pkg::*;
#(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [N-1:0]     mask,
  output logic [W-1:0]     lowest,
  output logic [N-1:0]     casc,
  output logic             sel_svc,
  output logic             poll_arm,
  output logic             init_clr,
  output logic             eoi_spec,
  output logic             eoi_ns,
  output logic [W-1:0]     eoi_lvl,
  output logic             busy
);
  seq_t   state;
  logic   need_mode;
  rdsel_t sel;
  logic   wr_cmd, cmd2, cmd3;

  assign wr_cmd   = wr_en && !addr;
  assign init_clr = wr_cmd && wdata[4];
  assign cmd2     = wr_cmd && !wdata[4] && !wdata[3];
  assign cmd3     = wr_cmd && !wdata[4] && wdata[3];
  assign eoi_spec = cmd2 && (wdata[7:5] == OP_SP_EOI);
  assign eoi_ns   = cmd2 && (wdata[7:5] == OP_NS_EOI);
  assign eoi_lvl  = wdata[W-1:0];
  assign busy     = (state != SEQ_RUN);
  assign sel_svc  = (sel == SEL_SVC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_RUN;
      need_mode <= 1'b0;
      mask      <= '0;
      lowest    <= W'(N - 1);
      casc      <= '0;
      sel       <= SEL_REQ;
      poll_arm  <= 1'b0;
    end else begin
      if (init_clr) begin
        state     <= SEQ_VEC;
        need_mode <= wdata[0];
        mask      <= '0;
        lowest    <= W'(N - 1);
        sel       <= SEL_REQ;
        poll_arm  <= 1'b0;
      end else if (wr_en && addr) begin
        case (state)
          SEQ_VEC:  state <= SEQ_CASC;
          SEQ_CASC: begin
            casc  <= wdata[N-1:0];
            state <= need_mode ? SEQ_MODE : SEQ_RUN;
          end
          SEQ_MODE: state <= SEQ_RUN;
          default:  mask  <= wdata[N-1:0];
        endcase
      end else if (cmd3) begin
        if (wdata[2]) poll_arm <= 1'b1;
        if (wdata[1]) sel <= wdata[0] ? SEL_SVC : SEL_REQ;
      end else if (cmd2 && (wdata[7:5] == OP_SET_LOW)) begin
        lowest <= wdata[W-1:0];
      end
      if (rd_en && !addr) poll_arm <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line,
  input  logic [N-1:0] lvl_mode,
  input  logic [N-1:0] ack,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;

  for (genvar n = 0; n < N; n++) begin : g_in
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[n] <= 1'b0;
        irr[n]  <= 1'b0;
      end else begin
        prev[n] <= line[n];
        if (lvl_mode[n])              irr[n] <= line[n];
        else if (line[n] && !prev[n]) irr[n] <= 1'b1;
        else if (ack[n])              irr[n] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] lowest,
  output logic         any,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rank
);
  logic [W-1:0] cand [N];

  for (genvar k = 0; k < N; k++) begin : g_cand
    assign cand[k] = lowest + W'(k + 1);
  end

  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    rank = '0;
    for (int k = 0; k < N; k++) begin
      if (!any && vec[cand[k]]) begin
        any  = 1'b1;
        lvl  = cand[k];
        rank = W'(k);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  localparam int LW = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_line,
  input  logic [NUM_IN-1:0] irq_level,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              int_out,
  output logic [NUM_IN-1:0] casc_sel,
  output logic              casc_req
);
  logic [NUM_IN-1:0] mask_r, irr, isr, isr_nx, ack_vec, casc;
  logic [LW-1:0]     lowest, eoi_lvl, req_lvl, req_rank, svc_lvl, svc_rank;
  logic              sel_svc, poll_arm, init_clr, eoi_spec, eoi_ns, cfg_busy;
  logic              req_any, svc_any, int_cond, poll_rd, poll_hit;

  pic_cfg_seq #(.N(NUM_IN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .mask(mask_r), .lowest(lowest),
    .casc(casc), .sel_svc(sel_svc), .poll_arm(poll_arm),
    .init_clr(init_clr), .eoi_spec(eoi_spec), .eoi_ns(eoi_ns),
    .eoi_lvl(eoi_lvl), .busy(cfg_busy)
  );

  pic_req_latch #(.N(NUM_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .line(irq_line), .lvl_mode(irq_level),
    .ack(ack_vec), .irr(irr)
  );

  pic_prio_pick #(.N(NUM_IN)) u_pick_req (
    .vec(irr & ~mask_r), .lowest(lowest),
    .any(req_any), .lvl(req_lvl), .rank(req_rank)
  );

  pic_prio_pick #(.N(NUM_IN)) u_pick_svc (
    .vec(isr), .lowest(lowest),
    .any(svc_any), .lvl(svc_lvl), .rank(svc_rank)
  );

  // A request wins the host only if it outranks everything in service.
  assign int_cond = req_any && (!svc_any || (req_rank < svc_rank));
  assign poll_rd  = bus_rd && !bus_addr && poll_arm;
  assign poll_hit = poll_rd && int_cond;
  assign ack_vec  = poll_hit ? (NUM_IN'(1) << req_lvl) : '0;

  always_comb begin
    isr_nx = isr;
    if (eoi_spec)          isr_nx[eoi_lvl] = 1'b0;
    if (eoi_ns && svc_any) isr_nx[svc_lvl] = 1'b0;
    if (poll_hit)          isr_nx[req_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        isr <= '0;
    else if (init_clr) isr <= '0;
    else               isr <= isr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr)     bus_rdata <= BUS_W'(mask_r);
      else if (poll_rd) bus_rdata <= poll_hit ? {1'b1, {(BUS_W-1-LW){1'b0}}, req_lvl} : '0;
      else if (sel_svc) bus_rdata <= BUS_W'(isr);
      else              bus_rdata <= BUS_W'(irr);
    end
  end

  assign int_out  = int_cond;
  assign casc_sel = casc;
  assign casc_req = int_cond && casc[req_lvl];
endmodule

// File: rtl/pic_sva.sv
module pic_sva #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic         bus_addr,
  input logic [7:0]   bus_wdata,
  input logic         int_out,
  input logic         casc_req,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask_r,
  input logic         cfg_busy
);
  assert_int_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask_r) != '0));

  assert_casc_needs_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
    casc_req |-> int_out);

  assert_spec_eoi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !bus_addr && bus_wdata[7:3] == 5'b01100)
      |=> !isr[$past(bus_wdata[2:0])]);

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && !cfg_busy) |=> (mask_r == $past(bus_wdata[N-1:0])));

  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !bus_addr && bus_wdata[4])
      |=> (isr == '0 && mask_r == '0 && cfg_busy));
endmodule

bind prio_irq_ctrl pic_sva #(.N(NUM_IN)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .int_out(int_out),
  .casc_req(casc_req), .irr(irr), .isr(isr), .mask_r(mask_r),
  .cfg_busy(cfg_busy)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_line = '0;
  logic [7:0] irq_level = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_out;
  logic [7:0] casc_sel;
  logic       casc_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_level(irq_level),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_out(int_out),
    .casc_sel(casc_sel), .casc_req(casc_req)
  );

  task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] bits);
    @(negedge clk);
    irq_line = irq_line | bits;
    @(negedge clk);
    irq_line = irq_line & ~bits;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare each read result one edge after the strobe is sampled.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11: unexpected read got 0x%02h expected none", bus_rdata);
        end else begin
          check8(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // Reset state
    check8({7'b0, int_out}, 8'h00, "R1 int_out after reset");
    check8(casc_sel, 8'h00, "R1 casc_sel after reset");
    rd(1'b1, 8'h00, "R1 mask after reset");
    rd(1'b0, 8'h00, "R1 request reg after reset");

    // Init without fourth word: third address-1 write lands in the mask
    wr(1'b0, 8'h10); wr(1'b1, 8'h00); wr(1'b1, 8'h04); wr(1'b1, 8'hA5);
    rd(1'b1, 8'hA5, "R2 mask after short init");
    check8(casc_sel, 8'h04, "R10 cascade byte");
    // Full init with fourth word
    wr(1'b0, 8'h11);
    rd(1'b1, 8'h00, "R2 start clears mask");
    wr(1'b1, 8'h00); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R2 fourth word not taken as mask");
    wr(1'b1, 8'hFF);
    rd(1'b1, 8'hFF, "R3 mask all");

    // Masked request latched but silent
    pulse(8'h08);
    check8({7'b0, int_out}, 8'h00, "R3 masked input silent");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h08, "R8 request readback while masked");
    wr(1'b1, 8'h00);
    check8({7'b0, int_out}, 8'h01, "R6 int after unmask");
    check8({7'b0, casc_req}, 8'h00, "R10 non-cascade winner");

    // Default priority: level 1 beats 3 and 5
    pulse(8'h22);
    rd(1'b0, 8'h2A, "R9 edge latches");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h81, "R7 poll default order");
    check8({7'b0, int_out}, 8'h00, "R6 blocked by in-service 1");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h02, "R8 in-service readback");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h28, "R7 poll cleared request 1");
    wr(1'b0, 8'h61);
    check8({7'b0, int_out}, 8'h01, "R5 specific EOI re-raises int");

    // Rotate: lowest = 2
    wr(1'b0, 8'hC2);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h83, "R4 level 3 first after rotation");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R7 poll blocked by higher in-service");
    wr(1'b0, 8'h63);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R7 poll level 5");
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R5 non-specific EOI");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R7 poll with nothing pending");
    check8({7'b0, int_out}, 8'h00, "R6 idle int low");
    pulse(8'h82);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h87, "R4 level 7 outranks 1 when 2 is lowest");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h80, "R8 in-service bit 7 set");
    wr(1'b0, 8'h67);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h81, "R4 level 1 next");
    wr(1'b0, 8'h61);

    // Level-sensitive input 6
    wr(1'b0, 8'h0A);
    @(negedge clk);
    irq_level = 8'h40; irq_line = 8'h40;
    @(negedge clk);
    check8({7'b0, int_out}, 8'h01, "R9 level input raises int");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h86, "R9 poll level input");
    rd(1'b0, 8'h40, "R9 level request survives ack");
    @(negedge clk);
    irq_line = 8'h00;
    @(negedge clk);
    rd(1'b0, 8'h00, "R9 level request follows line");
    wr(1'b0, 8'h66);
    // Edge input held high does not re-request
    @(negedge clk);
    irq_line = 8'h10;
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h84, "R9 edge poll");
    wr(1'b0, 8'h64);
    rd(1'b0, 8'h00, "R9 held edge line no new request");
    check8({7'b0, int_out}, 8'h00, "R9 held edge int low");
    irq_line = 8'h00;

    // Cascade input
    pulse(8'h04);
    check8({7'b0, casc_req}, 8'h01, "R10 cascade request flagged");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h82, "R10 poll reports cascade level");
    check8({7'b0, casc_req}, 8'h00, "R10 flag drops after ack");
    wr(1'b0, 8'h62);

    // Masked level excluded from poll
    wr(1'b1, 8'h20);
    pulse(8'h20);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R3 masked level not polled");
    wr(1'b1, 8'h00);
    check8({7'b0, int_out}, 8'h01, "R3 unmask releases request");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R7 poll after unmask");
    idle(4);
    check8(bus_rdata, 8'h85, "R11 read data held");
    wr(1'b0, 8'h65);
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: got %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule